// File: doc/BRIEF.md
# Folded SHA-256 Compression Engine

This block evaluates the 64-round SHA-256 compression function for one message block at a time. It settles several rounds per clock by placing the round logic back to back with no register between them, so flops exist only where one fold ends and the next begins. The number of rounds per clock is a parameter and may be 1, 4 or 8. Each pass therefore lasts 64, 16 or 8 cycles.

The block does not expand the message and never adds round constants. The surrounding logic supplies each round's schedule word already summed with its constant: one premixed word per round, for the rounds of the current fold. A start strobe captures the eight-word chaining value. When the last fold resolves, the block adds the working words back onto the captured chaining value, presents the digest and raises a one-cycle done pulse.

Top module: `sha_fold_core`

## Requirements
- R1: Each round forms T1 = h + Σ1(e) + Ch(e,f,g) + WK and T2 = Σ0(a) + Maj(a,b,c), with all sums taken modulo 2^32. The next state is a = T1+T2 and e = d+T1, and the remaining words shift: b←a, c←b, d←c, f←e, g←f, h←g.
  - Σ0 is the XOR of rotate-right by 2, 13 and 22.
  - Σ1 is the XOR of rotate-right by 6, 11 and 25.
  - Ch = g ^ (e & (f ^ g)).
  - Maj = (a & (b | c)) | (b & c).
- R2: Each digest word equals the captured chaining word plus the matching final working word, modulo 2^32. Carries wrap within the word.
- R3: `done` is high during exactly one cycle. That cycle follows the accepting clock edge by 64/RPC rising edges.
- R4: A `start` that arrives while `busy` is high has no effect. The pass in flight completes with its original chaining value and on its original schedule.
- R5: `busy` is high from the edge after an accepted start until the edge that raises `done`.
- R6: `wk_in` carries RPC words per cycle. Bits [32j+31:32j] hold round (fold*RPC + j), so the lowest round index sits in the lowest bits. Fold 0 is presented in the first cycle that `busy` is high. Every legal RPC yields the same digest for the same inputs.
- R7: After reset, `busy` and `done` are low and `digest` is zero.
- R8: `digest` holds its value from one completion until the next.
- R9: The padded one-block message "abc" with the standard initial chaining value hashes to ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.

Words a..h are packed into 256-bit ports with a in bits [255:224] and h in bits [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass; accepted only while idle |
| init_state | input | 256 | Chaining value a..h, captured on an accepted start |
| wk_in | input | 32*RPC | Premixed W+K words for the current fold |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle completion strobe |
| digest | output | 256 | Chaining value plus final working words |

## Verification
The bench builds three instances, with one, four and eight rounds per clock. All three run the same directed and random cases, and their digests are compared against one reference model. This exercises the full-length single-round schedule as well as the four- and eight-deep combinational cascades. It also confirms that the fold slicing of `wk_in` preserves round order in every variant. With eight-cycle passes, the timing of the done pulse and a mid-pass restart attempt can be examined at short run lengths.

// File: rtl/sha_fold_pkg.sv
package sha_fold_pkg;
  localparam int WORD_W       = 32;
  localparam int TOTAL_ROUNDS = 64;

  typedef struct packed {
    logic [31:0] a, b, c, d, e, f, g, h;
  } wstate_t;

  function automatic logic [31:0] rotr(input logic [31:0] x, input int unsigned n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] big_sig0(input logic [31:0] x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic logic [31:0] big_sig1(input logic [31:0] x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic logic [31:0] choose(input logic [31:0] x, y, z);
    return z ^ (x & (y ^ z));
  endfunction

  function automatic logic [31:0] majority(input logic [31:0] x, y, z);
    return (x & (y | z)) | (y & z);
  endfunction

  // One compression round fed with a premixed schedule+constant word.
  function automatic wstate_t one_round(input wstate_t s, input logic [31:0] wk);
    logic [31:0] t1, t2;
    wstate_t n;
    t1  = s.h + big_sig1(s.e) + choose(s.e, s.f, s.g) + wk;
    t2  = big_sig0(s.a) + majority(s.a, s.b, s.c);
    n.a = t1 + t2;
    n.b = s.a;
    n.c = s.b;
    n.d = s.c;
    n.e = s.d + t1;
    n.f = s.e;
    n.g = s.f;
    n.h = s.g;
    return n;
  endfunction

  function automatic wstate_t add_state(input wstate_t x, input wstate_t y);
    wstate_t r;
    r.a = x.a + y.a;
    r.b = x.b + y.b;
    r.c = x.c + y.c;
    r.d = x.d + y.d;
    r.e = x.e + y.e;
    r.f = x.f + y.f;
    r.g = x.g + y.g;
    r.h = x.h + y.h;
    return r;
  endfunction
endpackage

// File: rtl/sha_round_chain.sv
module sha_round_chain
  import sha_fold_pkg::*;
#(
  parameter int RPC = 4
) (
  input  wstate_t               s_in,
  input  logic [WORD_W*RPC-1:0] wk,
  output wstate_t               s_out
);
  wstate_t stg [0:RPC];

  assign stg[0] = s_in;

  // Rounds cascade with no register; lowest slice is the earliest round (R6).
  for (genvar i = 0; i < RPC; i++) begin : g_round
    assign stg[i+1] = one_round(stg[i], wk[WORD_W*i +: WORD_W]);
  end

  assign s_out = stg[RPC];
endmodule

// File: rtl/sha_fold_ctrl.sv
module sha_fold_ctrl #(
  parameter int GROUPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic last,
  output logic done
);
  localparam int CW = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(GROUPS - 1);

  logic [CW-1:0] cnt;

  assign load = start & ~busy;
  assign last = busy & (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + CW'(1);
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !busy));
  // R5
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && cnt == '0));
  // R4
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/sha_fold_core.sv
module sha_fold_core
  import sha_fold_pkg::*;
#(
  parameter int RPC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [255:0]          init_state,
  input  logic [WORD_W*RPC-1:0] wk_in,
  output logic                  busy,
  output logic                  done,
  output logic [255:0]          digest
);
  localparam int GROUPS = TOTAL_ROUNDS / RPC;

  wstate_t init_r, work_r, chain_out, digest_r;
  logic    load, last;

  sha_fold_ctrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .load  (load),
    .last  (last),
    .done  (done)
  );

  sha_round_chain #(.RPC(RPC)) u_chain (
    .s_in  (work_r),
    .wk    (wk_in),
    .s_out (chain_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_r   <= '0;
      work_r   <= '0;
      digest_r <= '0;
    end else begin
      if (load) begin
        init_r <= wstate_t'(init_state);
        work_r <= wstate_t'(init_state);
      end else if (busy) begin
        work_r <= chain_out;
      end
      if (last) digest_r <= add_state(init_r, chain_out);
    end
  end

  assign digest = digest_r;

  // R8
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(digest_r));
  // R4
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(init_r));
endmodule

// File: tb/sha_fold_core_test.sv
module sha_fold_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         st1 = 1'b0, st4 = 1'b0, st8 = 1'b0;
  logic [255:0] init_bus = '0;
  logic [255:0] wk_bus = '0;
  logic         busy1, busy4, busy8, done1, done4, done8;
  logic [255:0] dig1, dig4, dig8;

  sha_fold_core #(.RPC(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(st4), .init_state(init_bus),
    .wk_in(wk_bus[127:0]), .busy(busy4), .done(done4), .digest(dig4));
  sha_fold_core #(.RPC(1)) uut_r1 (
    .clk(clk), .rst_n(rst_n), .start(st1), .init_state(init_bus),
    .wk_in(wk_bus[31:0]), .busy(busy1), .done(done1), .digest(dig1));
  sha_fold_core #(.RPC(8)) uut_r8 (
    .clk(clk), .rst_n(rst_n), .start(st8), .init_state(init_bus),
    .wk_in(wk_bus[255:0]), .busy(busy8), .done(done8), .digest(dig8));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] wk_arr [64];

  localparam logic [31:0] KTAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  // Reference model: standard-form Ch/Maj, shift register via locals.
  function automatic logic [255:0] ref_digest(input logic [255:0] iv);
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    {a, b, c, d, e, f, g, h} = iv;
    for (int t = 0; t < 64; t++) begin
      t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) | (~e & g)) + wk_arr[t];
      t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1;
      d = c; c = b; b = a; a = t1 + t2;
    end
    return {iv[255:224] + a, iv[223:192] + b, iv[191:160] + c, iv[159:128] + d,
            iv[127:96] + e, iv[95:64] + f, iv[63:32] + g, iv[31:0] + h};
  endfunction

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic set_start(input int rpc, input logic v);
    case (rpc)
      1: st1 = v;
      4: st4 = v;
      default: st8 = v;
    endcase
  endtask

  function automatic logic get_busy(input int rpc);
    return (rpc == 1) ? busy1 : (rpc == 4) ? busy4 : busy8;
  endfunction
  function automatic logic get_done(input int rpc);
    return (rpc == 1) ? done1 : (rpc == 4) ? done4 : done8;
  endfunction
  function automatic logic [255:0] get_dig(input int rpc);
    return (rpc == 1) ? dig1 : (rpc == 4) ? dig4 : dig8;
  endfunction

  // One pass through the instance with the given rounds per clock.
  task automatic run_dut(input int rpc, input logic [255:0] iv, input bit poke, input string tag);
    int n = 64 / rpc;
    logic [255:0] exp = ref_digest(iv);
    bit early = 0, idle = 0;
    @(negedge clk);
    init_bus = iv;
    set_start(rpc, 1'b1);
    @(negedge clk);
    set_start(rpc, 1'b0);
    // R5: busy right after the accepting edge
    check({"R5 busy ", tag}, {255'd0, get_busy(rpc)}, 256'd1);
    for (int g = 0; g < n; g++) begin
      if (get_done(rpc)) early = 1;
      if (!get_busy(rpc)) idle = 1;
      wk_bus = '0;
      for (int j = 0; j < rpc; j++) wk_bus[32*j +: 32] = wk_arr[g*rpc + j];
      if (poke && g == n/2) begin
        // R4: restart attempt mid-pass with a different chaining value
        set_start(rpc, 1'b1);
        init_bus = ~iv;
      end else begin
        set_start(rpc, 1'b0);
      end
      @(negedge clk);
    end
    set_start(rpc, 1'b0);
    check({"R3 no early done ", tag}, {255'd0, early}, 256'd0);
    check({"R5 busy held ", tag}, {255'd0, idle}, 256'd0);
    check({"R3 done on cycle ", tag}, {254'd0, get_done(rpc), get_busy(rpc)}, 256'd2);
    check({"R1 R2 R6 digest ", tag}, get_dig(rpc), exp);
    @(negedge clk);
    check({"R3 single pulse ", tag}, {255'd0, get_done(rpc)}, 256'd0);
    check({"R8 digest hold ", tag}, get_dig(rpc), exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w [64];
    logic [255:0] iv_std, abc_exp, rnd;
    int rates [3] = '{1, 4, 8};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7
    check("R7 reset idle", {250'd0, busy1, busy4, busy8, done1, done4, done8}, 256'd0);
    check("R7 reset digest", dig1 | dig4 | dig8, 256'd0);

    // R9: message block "abc", padded
    for (int t = 0; t < 16; t++) w[t] = 32'd0;
    w[0] = 32'h61626380;
    w[15] = 32'h00000018;
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int t = 0; t < 64; t++) wk_arr[t] = w[t] + KTAB[t];
    iv_std = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
              32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    abc_exp = {32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
               32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
    check("R9 model abc", ref_digest(iv_std), abc_exp);
    foreach (rates[k]) begin
      run_dut(rates[k], iv_std, 1'b0, "abc");
      check("R9 abc digest", get_dig(rates[k]), abc_exp);
    end

    // R2: carries wrap with all-ones chaining value and zero WK words
    for (int t = 0; t < 64; t++) wk_arr[t] = 32'd0;
    foreach (rates[k]) run_dut(rates[k], {256{1'b1}}, 1'b0, "wrap");

    // R4: start while busy is ignored
    for (int t = 0; t < 64; t++) wk_arr[t] = $urandom;
    foreach (rates[k]) run_dut(rates[k], iv_std, 1'b1, "poke");

    // R1 R6: random chaining values and WK streams, all fold depths
    for (int it = 0; it < 5; it++) begin
      for (int t = 0; t < 64; t++) wk_arr[t] = $urandom;
      for (int q = 0; q < 8; q++) rnd[32*q +: 32] = $urandom;
      foreach (rates[k]) run_dut(rates[k], rnd, 1'b0, "random");
      // R6: all fold depths agree
      check("R6 rpc agree 1v4", dig1, dig4);
      check("R6 rpc agree 4v8", dig4, dig8);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule